// File: doc/BRIEF.md
# Dual-Rate Split-Port Burst SRAM Model

This block is a synthesizable behavioural model of a pipelined burst SRAM. It has one shared address bus, a write data port and a separate read data port. It runs from a single clock, `clk`, at twice the command rate. Successive edges of `clk` stand for the rising edges of the input clock pair: a K rising edge, then a K# rising edge, alternating. The output `k_phase` tells the host which one comes next. The word width is a parameter (18 or 36 bits, in 9-bit byte lanes), and the array is scaled down to `2**AW` words.

Commands are sampled only at K rising edges. Every read or write command moves exactly two words: the addressed word first, then its partner in the aligned pair. Write data arrives one K cycle late, one beat on each phase. Read data leaves two edges after the command, one word per phase. It is launched either on the K phases or on rising edges of a separate output clock pair (`c_clk`, `cn_clk`).

Both data streams run at a fixed rate with no back-pressure. There is no ready signal in either direction. A write beat is taken whether or not the host is ready, and read words appear with `qvld` high whether or not the receiver can accept them. The receiver must take every word on the phase it is valid. When no read word is being launched, the output pad enable `q_oe` falls, which models a high-impedance read bus.

Top module: `ddr_sio_sram`

## Requirements
- R1: `ld`/`rw` are sampled only at edges where `k_phase` was 0 before the edge (K rising edge). `ld`=1 with `rw`=1 starts a read and `ld`=1 with `rw`=0 starts a write. At edges where `k_phase` was 1, `ld`, `rw` and `addr` have no effect.
- R2: `k_phase` is 0 in reset and inverts on every `clk` edge afterwards, so the first edge after reset release is a K rising edge.
- R3: A read command at K edge E puts word `addr` on `q` after edge E+2 and the word whose address has its LSB inverted after edge E+3. The second address wraps within the aligned pair.
- R4: Read commands on consecutive K edges stream out with no gap: `qvld` stays high across every phase in between.
- R5: A write command at K edge E stores `d` into word `addr` at edge E+2 and stores `d` into word `addr` with its LSB inverted at edge E+3.
- R6: `bwe[i]` enables bits 9i+8:9i of a write beat. A lane whose enable is 0 keeps its old content. 36-bit width has 4 lanes; 18-bit width has 2.
- R7: `d` and `bwe` at edges that carry no write beat have no effect on the array.
- R8: `qvld` and `q_oe` are high exactly on the phases that carry a read word and low otherwise, including in reset. After the last burst word they fall at the next K rising edge.
- R9: A read returns the data of every write commanded at an earlier K edge, including a write commanded one K cycle earlier to the same pair. A write commanded one K cycle after a read does not change the read words.
- R10: When `c_clk` and `cn_clk` are both high at an edge, read words launch on the K phases. Otherwise a word for a K-rising phase launches only if `c_clk` rose, a K#-rising phase word only if `cn_clk` rose (rise = high now, low at the previous edge), and a phase with no launch holds the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-rate clock; alternate edges are K and K# rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| ld | input | 1 | Load enable: a command is present at a K rising edge |
| rw | input | 1 | Direction: 1 read, 0 write |
| addr | input | AW | Word address of the command |
| d | input | DW | Write data beat |
| bwe | input | DW/9 | Per-lane write enables for the current beat |
| c_clk | input | 1 | Output clock, sampled level |
| cn_clk | input | 1 | Inverted output clock, sampled level |
| k_phase | output | 1 | 0: the next edge is a K rising edge |
| q | output | DW | Read data word |
| q_oe | output | 1 | Read pad drive enable (low means high impedance) |
| qvld | output | 1 | Echo valid: `q` carries a read word |

## Verification
The checker watches the timing skeleton on every cycle. It checks that `k_phase` alternates, that `qvld` rises and falls only after K rising edges, that a read command at a K edge is followed three and four samples later by valid words, and that no valid word appears without such a command. Data content cannot be judged by a property. Lane merging, pair wrap, ignored odd-phase commands, late-write ordering against reads, and the two output-clock modes are covered only by the bench scenarios, where a behavioural reference array is compared on every edge.

// File: rtl/ddr_sio_pkg.sv
`timescale 1ns/1ps
package ddr_sio_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } sio_cmd_e;

  function automatic sio_cmd_e decode_cmd(input logic ld, input logic rw);
    if (!ld) return CMD_NOP;
    return rw ? CMD_RD : CMD_WR;
  endfunction
endpackage

// File: rtl/ddr_sio_array.sv
`timescale 1ns/1ps
module ddr_sio_array import ddr_sio_pkg::*; #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DW-1:0]              wdata,
  input  logic [DW/LANE_W-1:0]       wbe,
  input  logic [AW-1:0]              raddr,
  output logic [DW-1:0]              rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned LANES = DW / LANE_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cur;
  logic [DW-1:0] merged;

  assign cur = mem[waddr];

  // Per-lane merge of the incoming beat with the stored word
  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign merged[gl*LANE_W +: LANE_W] =
      wbe[gl] ? wdata[gl*LANE_W +: LANE_W] : cur[gl*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= merged;
  end

  // Read sees the array before this edge's write
  assign rdata = mem[raddr];
endmodule

// File: rtl/ddr_sio_cmd.sv
`timescale 1ns/1ps
module ddr_sio_cmd import ddr_sio_pkg::*; #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  output logic          k_ph,
  output logic          rd_v,
  output logic [AW-1:0] rd_a,
  output logic          wr_v,
  output logic [AW-1:0] wr_a
);
  sio_cmd_e cmd;
  logic [1:0]         bv;
  logic [1:0][AW-1:0] ba;

  assign cmd = decode_cmd(ld, rw);

  // Phase bit doubles as the burst counter LSB
  always_ff @(posedge clk) begin
    if (!rst_n) k_ph <= 1'b0;
    else        k_ph <= ~k_ph;
  end

  // Index 0: read pipe, index 1: write pipe
  for (genvar gd = 0; gd < 2; gd++) begin : g_dir
    localparam sio_cmd_e MATCH = (gd == 0) ? CMD_RD : CMD_WR;
    logic          s0_v, s1_v;
    logic [AW-1:0] s0_a, s1_a;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s0_v <= 1'b0;
        s1_v <= 1'b0;
        s0_a <= '0;
        s1_a <= '0;
      end else if (!k_ph) begin
        s0_v <= (cmd == MATCH);
        s0_a <= addr;
        s1_v <= s0_v;
        s1_a <= s0_a;
      end
    end

    assign bv[gd] = k_ph ? s1_v : s0_v;
    assign ba[gd] = k_ph ? {s1_a[AW-1:1], ~s1_a[0]} : s0_a;
  end

  assign rd_v = bv[0];
  assign rd_a = ba[0];
  assign wr_v = bv[1];
  assign wr_a = ba[1];
endmodule

// File: rtl/ddr_sio_oclk.sv
`timescale 1ns/1ps
module ddr_sio_oclk #(
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          k_ph,
  input  logic          c_clk,
  input  logic          cn_clk,
  input  logic          beat_v,
  input  logic [DW-1:0] beat_d,
  output logic [DW-1:0] q,
  output logic          drive
);
  logic c_q, cn_q;
  logic tied, c_edge, cn_edge, launch;

  always_comb begin
    tied    = c_clk & cn_clk;
    c_edge  = c_clk & ~c_q;
    cn_edge = cn_clk & ~cn_q;
    launch  = tied | (k_ph ? cn_edge : c_edge);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q   <= 1'b1;
      cn_q  <= 1'b1;
      drive <= 1'b0;
      q     <= '0;
    end else begin
      c_q  <= c_clk;
      cn_q <= cn_clk;
      if (launch) begin
        drive <= beat_v;
        q     <= beat_d;
      end
    end
  end
endmodule

// File: rtl/ddr_sio_sram.sv
`timescale 1ns/1ps
module ddr_sio_sram import ddr_sio_pkg::*; #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic                 rw,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        d,
  input  logic [DW/LANE_W-1:0] bwe,
  input  logic                 c_clk,
  input  logic                 cn_clk,
  output logic                 k_phase,
  output logic [DW-1:0]        q,
  output logic                 q_oe,
  output logic                 qvld
);
  logic          rd_v, wr_v, drive;
  logic [AW-1:0] rd_a, wr_a;
  logic [DW-1:0] rdata;

  ddr_sio_cmd #(.AW(AW)) i_cmd (
    .clk(clk), .rst_n(rst_n), .ld(ld), .rw(rw), .addr(addr),
    .k_ph(k_phase), .rd_v(rd_v), .rd_a(rd_a), .wr_v(wr_v), .wr_a(wr_a)
  );

  ddr_sio_array #(.AW(AW), .DW(DW)) i_array (
    .clk(clk), .we(wr_v), .waddr(wr_a), .wdata(d), .wbe(bwe),
    .raddr(rd_a), .rdata(rdata)
  );

  ddr_sio_oclk #(.DW(DW)) i_oclk (
    .clk(clk), .rst_n(rst_n), .k_ph(k_phase), .c_clk(c_clk), .cn_clk(cn_clk),
    .beat_v(rd_v), .beat_d(rdata), .q(q), .drive(drive)
  );

  assign q_oe = drive;
  assign qvld = drive;
endmodule

// File: rtl/ddr_sio_sram_chk.sv
`timescale 1ns/1ps
module ddr_sio_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic ld,
  input logic rw,
  input logic k_phase,
  input logic qvld
);
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (k_phase != $past(k_phase)));  // R2

  AST_VALID_RISE_K: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qvld) |-> k_phase);  // R8

  AST_DESELECT_K: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qvld) |-> k_phase);  // R8

  AST_READ_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && rw && !k_phase) |-> ##3 qvld);  // R3

  AST_READ_WORD1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && rw && !k_phase) |-> ##4 qvld);  // R3

  AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qvld) |-> $past(ld && rw && !k_phase, 3));  // R1
endmodule

bind ddr_sio_sram ddr_sio_sram_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .rw(rw), .k_phase(k_phase), .qvld(qvld)
);

// File: tb/test_ddr_sio_sram.sv
`timescale 1ns/1ps
module test_ddr_sio_sram;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int LN = DW / 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0, rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic [LN-1:0] bwe = '0;
  logic c_clk = 1'b1, cn_clk = 1'b1;
  logic k_phase, q_oe, qvld;
  logic [DW-1:0] q;

  ddr_sio_sram #(.AW(AW), .DW(DW)) i_ddr_sio_sram (
    .clk(clk), .rst_n(rst_n), .ld(ld), .rw(rw), .addr(addr), .d(d), .bwe(bwe),
    .c_clk(c_clk), .cn_clk(cn_clk), .k_phase(k_phase), .q(q), .q_oe(q_oe), .qvld(qvld)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [DW-1:0] ref_mem [DEPTH];
  int            rq_due[$];
  logic [AW-1:0] rq_a[$];
  int            wq_due[$];
  logic [AW-1:0] wq_a[$];
  int   e = 0;
  bit   ctog = 1'b0;
  logic m_cp = 1'b1, m_cnp = 1'b1;
  logic exp_v = 1'b0;
  logic [DW-1:0] exp_q = '0;

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  function automatic logic [LN-1:0] rnd_be();
    logic [31:0] t;
    t = $urandom();
    return t[LN-1:0];
  endfunction

  function automatic logic [AW-1:0] rnd_addr();
    logic [31:0] t;
    t = $urandom();
    return t[AW-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (edge %0d)", tag, what, act, expv, e);
    end
  endtask

  // One clk edge: drive inputs, advance the reference, sample after the edge
  task automatic tick(input logic l, input logic r, input logic [AW-1:0] a,
                      input logic [DW-1:0] dd, input logic [LN-1:0] b, input string tag);
    bit ph;
    logic cc, ccn, launch, rv;
    logic [AW-1:0] ra, wa;
    ph  = e[0];
    cc  = ctog ? !ph : 1'b1;
    ccn = ctog ? ph  : 1'b1;
    ld = l; rw = r; addr = a; d = dd; bwe = b; c_clk = cc; cn_clk = ccn;
    chk(k_phase == ph, "R2", "k_phase", DW'(k_phase), DW'(ph));
    launch = (cc && ccn) || (ph ? (ccn && !m_cnp) : (cc && !m_cp));
    rv = 1'b0; ra = '0;
    if (rq_due.size() > 0 && rq_due[0] == e) begin
      rv = 1'b1; ra = rq_a[0];
      void'(rq_due.pop_front()); void'(rq_a.pop_front());
    end
    if (launch) begin
      exp_v = rv;
      if (rv) exp_q = ref_mem[ra];
    end
    if (wq_due.size() > 0 && wq_due[0] == e) begin
      wa = wq_a[0];
      for (int i = 0; i < LN; i++)
        if (b[i]) ref_mem[wa][i*9 +: 9] = dd[i*9 +: 9];
      void'(wq_due.pop_front()); void'(wq_a.pop_front());
    end
    if (!ph && l) begin
      if (r) begin
        rq_due.push_back(e + 2); rq_a.push_back(a);
        rq_due.push_back(e + 3); rq_a.push_back({a[AW-1:1], ~a[0]});
      end else begin
        wq_due.push_back(e + 2); wq_a.push_back(a);
        wq_due.push_back(e + 3); wq_a.push_back({a[AW-1:1], ~a[0]});
      end
    end
    m_cp = cc; m_cnp = ccn;
    e++;
    @(posedge clk);
    @(negedge clk);
    chk(qvld == exp_v, tag, "qvld", DW'(qvld), DW'(exp_v));
    chk(q_oe == exp_v, "R8", "q_oe", DW'(q_oe), DW'(exp_v));
    if (exp_v) chk(q == exp_q, tag, "q", q, exp_q);
  endtask

  // One K cycle: command edge, then a K# edge carrying random ld/rw (R1: ignored)
  task automatic kcyc(input logic l, input logic r, input logic [AW-1:0] a,
                      input bit full_be, input string tag);
    tick(l, r, a, rnd_word(), full_be ? {LN{1'b1}} : rnd_be(), tag);
    tick(1'($urandom()), 1'($urandom()), rnd_addr(), rnd_word(),
         full_be ? {LN{1'b1}} : rnd_be(), tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) kcyc(1'b0, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(qvld == 1'b0, "R8", "reset qvld", DW'(qvld), '0);
    chk(q_oe == 1'b0, "R8", "reset q_oe", DW'(q_oe), '0);
    chk(k_phase == 1'b0, "R2", "reset k_phase", DW'(k_phase), '0);
    rst_n = 1'b1;

    // R5: fill every pair with streaming writes, full lanes
    for (int i = 0; i < DEPTH / 2; i++) kcyc(1'b1, 1'b0, AW'(2 * i), 1'b1, "R5");
    idle(2, "R7");

    // R3: isolated reads, odd and even start address (pair wrap)
    kcyc(1'b1, 1'b1, AW'(5), 1'b0, "R3");
    idle(3, "R8");
    kcyc(1'b1, 1'b1, AW'(8), 1'b0, "R3");
    idle(3, "R8");

    // R10: output clock pair toggling
    ctog = 1'b1;
    idle(2, "R10");
    for (int i = 0; i < 8; i++) kcyc(1'b1, 1'b1, AW'(3 * i), 1'b0, "R4");
    idle(3, "R8");

    // R6: partial-lane write then read back
    kcyc(1'b1, 1'b0, AW'(12), 1'b0, "R6");
    idle(1, "R7");
    kcyc(1'b1, 1'b1, AW'(12), 1'b0, "R6");
    idle(3, "R6");

    // R9: write immediately followed by reads of the same pair
    kcyc(1'b1, 1'b0, AW'(20), 1'b0, "R9");
    kcyc(1'b1, 1'b1, AW'(20), 1'b0, "R9");
    kcyc(1'b1, 1'b1, AW'(21), 1'b0, "R9");
    idle(3, "R9");
    // R9: read followed by a write to the same pair
    kcyc(1'b1, 1'b1, AW'(30), 1'b0, "R9");
    kcyc(1'b1, 1'b0, AW'(30), 1'b0, "R9");
    kcyc(1'b1, 1'b1, AW'(31), 1'b0, "R9");
    idle(3, "R9");

    // R1: commands only at K# edges are ignored
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 1'b0, '0, rnd_word(), rnd_be(), "R1");
      tick(1'b1, i[0], AW'(40), rnd_word(), {LN{1'b1}}, "R1");
    end
    idle(1, "R1");
    kcyc(1'b1, 1'b1, AW'(40), 1'b0, "R1");
    idle(3, "R1");

    // R10: back to tied-high output clocks, random traffic
    ctog = 1'b0;
    idle(2, "R10");
    for (int i = 0; i < 40; i++)
      kcyc(1'($urandom()), 1'($urandom()), rnd_addr(), 1'b0, "R10");
    idle(3, "R8");

    // R10: toggling output clocks, random traffic
    ctog = 1'b1;
    idle(2, "R10");
    for (int i = 0; i < 40; i++)
      kcyc(1'($urandom()), 1'($urandom()), rnd_addr(), 1'b0, "R10");
    idle(3, "R8");

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule